// File: doc/BRIEF.md
# Self-Starting Seven-Stage Pseudo-Random Bit Pattern Generator

This block produces a maximal-length pseudo-random bit pattern for link and equalizer testing. It runs at full rate: a seven-stage shift register advances once per enabled clock and emits one pattern bit per clock. Feedback is the XOR of the two most significant stages, which follows the primitive polynomial x^7 + x^6 + 1. The pattern therefore repeats every 127 bits.

Two auxiliary outputs carry the same pattern as the main output, but they run ahead of it. They are taken from register stages three and six positions before the last stage, so a receiver or comparator can line up against a shifted copy without a delay line of its own. A trigger output divides the enabled clock by two, which gives an oscilloscope a steady edge to synchronise on.

Synchronous reset clears every stage to zero. An XOR-only register would stay in that state forever. Built-in recovery forces a one into the first stage whenever all stages are zero, so the pattern starts by itself after every reset. Deasserting the enable input freezes both the pattern and the trigger.

Top module: `prbs_autostart_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, all seven stages and the trigger are cleared, so `prbs_out`, `lead3_out`, `lead6_out` and `trig_out` all read 0 after that edge.
- R2: On the first enabled edge out of the all-zero state, the register loads the value 1 into stage 1 only. After that edge `lead6_out` reads 1 and `prbs_out` reads 0. `prbs_out` first reads 1 after the seventh enabled edge.
- R3: Counting enabled edges since reset as k, with m(k) the value of `prbs_out` after edge k, the output obeys m(k+7) = m(k) XOR m(k+1) for every k of 1 or more.
- R4: The pattern on `prbs_out` has a period of exactly 127 enabled clocks, with no shorter period, and every 127-bit window holds 64 ones.
- R5: After startup the register never returns to all zeros. At the port this means `prbs_out` never shows more than six zeros in a row.
- R6: `lead3_out` leads `prbs_out` by three enabled clocks and `lead6_out` leads it by six: lead3(k) = m(k+3) and lead6(k) = m(k+6).
- R7: `trig_out` inverts on every enabled edge, so after k enabled edges since reset it equals bit 0 of k.
- R8: While `en` is low, the register and trigger hold their values and all four outputs stay constant. When `en` returns high, the pattern continues from where it stopped.
- R9: A reset in the middle of a run returns every output to 0. After release, the generator replays the same pattern from its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears register and trigger |
| en | input | 1 | Advance enable; low freezes pattern and trigger |
| prbs_out | output | 1 | Main pattern bit (last stage) |
| lead3_out | output | 1 | Same pattern, three bits ahead of `prbs_out` |
| lead6_out | output | 1 | Same pattern, six bits ahead of `prbs_out` |
| trig_out | output | 1 | Enabled clock divided by two |

## Verification
The bench builds the generator with its default settings: seven stages, taps on stages 7 and 6, and the auxiliary outputs taken from stages 4 and 1. With these settings one full 127-bit period fits in a few hundred clocks, so the bench can observe two complete periods, rule out every shorter period and count the ones in a window. The lead offsets of three and six bits can then be checked against the main output over the whole stream. Because reset clears the register to all zeros, every start in the bench, including the mid-run reset, goes through the lock-up recovery path.

// File: rtl/prbs_pkg.sv
`timescale 1ns/1ps
package prbs_pkg;

  // Register length and feedback taps (stage numbers count from 1).
  localparam int unsigned PRBS_W          = 7;
  localparam int unsigned PRBS_TAP_HI     = 7;
  localparam int unsigned PRBS_TAP_LO     = 6;
  // Default stages feeding the leading outputs.
  localparam int unsigned PRBS_NEAR_STAGE = 4;
  localparam int unsigned PRBS_FAR_STAGE  = 1;

  typedef logic [PRBS_W-1:0] prbs_state_t;

  // Linear part of the feedback.
  function automatic logic prbs_xor_taps(input prbs_state_t s);
    return s[PRBS_TAP_HI-1] ^ s[PRBS_TAP_LO-1];
  endfunction

  // All-zero lock-up detection.
  function automatic logic prbs_is_lockup(input prbs_state_t s);
    return ~|s;
  endfunction

  // Bit entering stage 1: XOR feedback, forced to 1 from lock-up.
  function automatic logic prbs_feed(input prbs_state_t s);
    return prbs_xor_taps(s) | prbs_is_lockup(s);
  endfunction

endpackage

// File: rtl/prbs_shift_core.sv
`timescale 1ns/1ps
module prbs_shift_core
  import prbs_pkg::*;
#(
  parameter int unsigned NEAR_STAGE = PRBS_NEAR_STAGE,
  parameter int unsigned FAR_STAGE  = PRBS_FAR_STAGE
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic main_bit,
  output logic near_bit,
  output logic far_bit
);

  prbs_state_t stage_q;
  prbs_state_t stage_d;
  logic        lockup_w;
  logic        feed_w;

  assign lockup_w = prbs_is_lockup(stage_q);
  assign feed_w   = prbs_feed(stage_q);

  always_comb begin
    if (en) stage_d = {stage_q[PRBS_W-2:0], feed_w};
    else    stage_d = stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_d;
  end

  assign main_bit = stage_q[PRBS_W-1];
  assign near_bit = stage_q[NEAR_STAGE-1];
  assign far_bit  = stage_q[FAR_STAGE-1];

  // R1: reset clears the register.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (stage_q == '0));

  // R2: lock-up recovery loads a single one into stage 1.
  assert_autostart_R2: assert property (@(posedge clk) disable iff (rst)
    (en && lockup_w) |=> (stage_q == prbs_state_t'(1)));

  // R3: enabled edges shift every stage up by one.
  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (stage_q[PRBS_W-1:1] == $past(stage_q[PRBS_W-2:0])));

  // R5: a running register never falls back into lock-up.
  assert_no_lockup_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !lockup_w) |=> !lockup_w);

  // R8: disabled edges leave the register untouched.
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(stage_q));

endmodule

// File: rtl/prbs_trig_div.sv
`timescale 1ns/1ps
module prbs_trig_div (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic trig
);

  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst)     trig_q <= 1'b0;
    else if (en) trig_q <= ~trig_q;
  end

  assign trig = trig_q;

  // R7: every enabled edge inverts the trigger.
  assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    en |=> (trig_q != $past(trig_q)));

  // R8: disabled edges freeze the trigger.
  assert_trig_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(trig_q));

endmodule

// File: rtl/prbs_autostart_gen.sv
`timescale 1ns/1ps
module prbs_autostart_gen
  import prbs_pkg::*;
#(
  parameter int unsigned NEAR_STAGE = PRBS_NEAR_STAGE,
  parameter int unsigned FAR_STAGE  = PRBS_FAR_STAGE
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic prbs_out,
  output logic lead3_out,
  output logic lead6_out,
  output logic trig_out
);

  localparam int unsigned NEAR_LEAD = PRBS_W - NEAR_STAGE;
  localparam int unsigned FAR_LEAD  = PRBS_W - FAR_STAGE;
  localparam int unsigned RUN_W     = $clog2(FAR_LEAD + 1);

  logic main_w, near_w, far_w, trig_w;

  prbs_shift_core #(
    .NEAR_STAGE (NEAR_STAGE),
    .FAR_STAGE  (FAR_STAGE)
  ) core_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .main_bit (main_w),
    .near_bit (near_w),
    .far_bit  (far_w)
  );

  prbs_trig_div trig_i (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .trig (trig_w)
  );

  assign prbs_out  = main_w;
  assign lead3_out = near_w;
  assign lead6_out = far_w;
  assign trig_out  = trig_w;

  // Consecutive enabled edges since reset or the last pause, saturating.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !en)                   run_q <= '0;
    else if (run_q != RUN_W'(FAR_LEAD)) run_q <= run_q + 1'b1;
  end

  // R6: the main bit equals each leading tap from the matching number of edges earlier.
  assert_near_lead_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q >= RUN_W'(NEAR_LEAD)) |-> (main_w == $past(near_w, NEAR_LEAD)));

  assert_far_lead_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q >= RUN_W'(FAR_LEAD)) |-> (main_w == $past(far_w, FAR_LEAD)));

endmodule

// File: tb/prbs_autostart_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_autostart_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic prbs_out, lead3_out, lead6_out, trig_out;

  int total = 0;
  int bad   = 0;
  int k     = 0;

  logic exp_m [0:639];
  logic obs_m [0:319];

  always #5 clk = ~clk;

  prbs_autostart_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .prbs_out  (prbs_out),
    .lead3_out (lead3_out),
    .lead6_out (lead6_out),
    .trig_out  (trig_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock; inputs change and outputs are read at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic adv();
    tick();
    if (en && !rst) k++;
  endtask

  task automatic test_reset_state();
    rst = 1'b1; en = 1'b1;
    repeat (3) tick();
    check("R1", "prbs_out in reset", prbs_out, 0);
    check("R1", "lead3_out in reset", lead3_out, 0);
    check("R1", "lead6_out in reset", lead6_out, 0);
    check("R1", "trig_out in reset", trig_out, 0);
  endtask

  task automatic test_autostart();
    rst = 1'b0; k = 0;
    adv();
    check("R2", "lead6_out after first edge", lead6_out, 1);
    check("R2", "prbs_out after first edge", prbs_out, 0);
    repeat (5) adv();
    check("R2", "prbs_out after sixth edge", prbs_out, 0);
    adv();
    check("R2", "prbs_out after seventh edge", prbs_out, 1);
  endtask

  // Runs to k=300 from wherever it is, comparing every output each edge.
  task automatic test_stream();
    int first_bad_k = -1;
    int bm = 0, bn = 0, bf = 0, bt = 0;
    for (int i = 0; i <= 7; i++) obs_m[i] = exp_m[i];
    while (k < 300) begin
      adv();
      obs_m[k] = prbs_out;
      if (prbs_out  != exp_m[k])   begin bm++; if (first_bad_k < 0) first_bad_k = k; end
      if (lead3_out != exp_m[k+3]) bn++;
      if (lead6_out != exp_m[k+6]) bf++;
      if (trig_out  != k[0])       bt++;
    end
    check("R3", "main stream mismatches vs recurrence model", bm, 0);
    check("R6", "lead3 mismatches vs main+3", bn, 0);
    check("R6", "lead6 mismatches vs main+6", bf, 0);
    check("R7", "trigger parity mismatches", bt, 0);
    bm = 0;
    for (int t = 1; t + 7 <= 300; t++)
      if (obs_m[t+7] != (obs_m[t] ^ obs_m[t+1])) bm++;
    check("R3", "observed recurrence violations", bm, 0);
  endtask

  task automatic test_period();
    int miss = 0, ones = 0, short_p = 0;
    for (int t = 1; t + 127 <= 300; t++) if (obs_m[t] != obs_m[t+127]) miss++;
    check("R4", "period-127 mismatches", miss, 0);
    for (int t = 1; t <= 127; t++) ones += int'(obs_m[t]);
    check("R4", "ones in one period", ones, 64);
    for (int p = 1; p < 127; p++) begin
      int same = 1;
      for (int t = 1; t <= 127; t++) if (obs_m[t] != obs_m[t+p]) same = 0;
      if (same != 0) short_p++;
    end
    check("R4", "shorter periods found", short_p, 0);
  endtask

  task automatic test_no_lockup();
    int run = 0, longest = 0;
    for (int t = 1; t <= 300; t++) begin
      if (obs_m[t] == 1'b0) run++; else run = 0;
      if (run > longest) longest = run;
    end
    check("R5", "longest zero run", longest, 6);
  endtask

  task automatic test_hold();
    logic m0, n0, f0, t0;
    int moved = 0;
    m0 = prbs_out; n0 = lead3_out; f0 = lead6_out; t0 = trig_out;
    en = 1'b0;
    repeat (12) begin
      adv();
      if (prbs_out != m0 || lead3_out != n0 || lead6_out != f0 || trig_out != t0) moved++;
    end
    check("R8", "output changes while disabled", moved, 0);
    en = 1'b1;
    adv();
    check("R8", "prbs_out after resume", prbs_out, exp_m[k]);
    check("R8", "lead6_out after resume", lead6_out, exp_m[k+6]);
    check("R8", "trig_out after resume", trig_out, k[0]);
  endtask

  task automatic test_midreset();
    int bm = 0;
    rst = 1'b1;
    repeat (2) tick();
    check("R9", "prbs_out in mid-run reset", prbs_out, 0);
    check("R9", "lead6_out in mid-run reset", lead6_out, 0);
    check("R9", "trig_out in mid-run reset", trig_out, 0);
    rst = 1'b0; k = 0;
    repeat (40) begin
      adv();
      if (prbs_out != exp_m[k] || lead3_out != exp_m[k+3] || lead6_out != exp_m[k+6]) bm++;
    end
    check("R9", "replay mismatches after reset", bm, 0);
  endtask

  initial begin
    // Expected pattern from R2 and R3: zeros up to k=6, a one at k=7, then the recurrence.
    for (int i = 0; i <= 6; i++) exp_m[i] = 1'b0;
    exp_m[7] = 1'b1;
    for (int i = 1; i + 7 <= 639; i++) exp_m[i+7] = exp_m[i] ^ exp_m[i+1];

    @(negedge clk);
    test_reset_state();
    test_autostart();
    test_stream();
    test_period();
    test_no_lockup();
    test_hold();
    test_midreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule